// File: doc/BRIEF.md
# Ethernet MAC Init Sequencer

This block brings an Ethernet MAC out of power-up into a working state without software. After reset it acts as a memory-mapped bus master and writes a fixed, ordered series of values into the MAC's configuration space. First it shuts both data paths and issues a software reset. It then waits for the reset to finish, loads the maximum frame length and the transmit inter-frame gap, and switches the data paths back on. For a MAC wired to an RGMII PHY, one more write switches on the receive/transmit clock timing adjustment through the MAC's management (MDIO) register window.

Each access is held on the bus until the slave drops waitrequest. Read data is taken in the cycle the read is accepted. All register offsets and data values are parameters, and the extra RGMII step is chosen by a static parameter. When the final access has been accepted, a done flag goes high and stays there until the next reset. Asserting reset again runs the whole sequence a second time.

Top module: `mac_init_seq`

## Requirements
- R1: While rst_n is low, avm_read, avm_write and init_done are low and avm_address is zero.
- R2: The first access writes VAL_OFF (default 0x0000_0000, both paths off) to CMD_OFS (default 0x08). The second writes VAL_SRST (default 0x0000_2000, the software reset bit) to CMD_OFS.
- R3: After the reset write, the block reads CMD_OFS repeatedly until a read returns data in which no bit of VAL_SRST is set. Reads only ever target CMD_OFS, and the access after that final read is the frame-length write.
- R4: After polling, three writes follow in order: VAL_FRM (default 0x0000_2580) to FRM_OFS (default 0x14), then VAL_IFG (default 0x0000_000C) to IFG_OFS (default 0x5C), then VAL_ON (default 0x0000_0003, both paths on) to CMD_OFS.
- R5: With WITH_RGMII=1, one further write of VAL_MDIO (default 0x0000_0082) to MDIO_OFS (default 0xA0) follows the path-enable write. With WITH_RGMII=0, the path-enable write is the last access.
- R6: While waitrequest is high, address, data, read and write stay unchanged. Read and write are never high together. An access counts as done only in a cycle where waitrequest is low.
- R7: init_done rises in the clock cycle right after the last access is accepted. It then stays high until reset, and no read or write is issued while it is high.
- R8: Pulling rst_n low again clears init_done, and after release the full sequence runs again from its first write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| avm_address | output | ADDR_W | Register address of the current access, zero when idle |
| avm_read | output | 1 | Read request |
| avm_write | output | 1 | Write request |
| avm_writedata | output | DATA_W | Write data, zero when no write is pending |
| avm_readdata | input | DATA_W | Read data, valid in the cycle a read is accepted |
| avm_waitrequest | input | 1 | Slave stall; the current access is held while high |
| init_done | output | 1 | Sequence complete, held until reset |

## Verification
The bench runs one RGMII and one SGMII instance side by side. Their slaves stall differently, from zero to three wait cycles per access, and they hold the reset bit busy for different numbers of polls. A design that moved on while stalled would log fewer or corrupted accesses. One that treated the reset as done after a single poll would log too few reads before the frame-length write. The bench also checks that done appears in the cycle right after the final acceptance. A design that added a step in SGMII mode, or dropped the MDIO write in RGMII mode, fails the per-instance access count. A design that did not restart on a second reset fails the rerun comparison.

// File: rtl/mac_init_pkg.sv
package mac_init_pkg;

  // kind of bus access a sequence step performs
  typedef enum logic {
    K_WR   = 1'b0,
    K_POLL = 1'b1
  } step_kind_e;

  // engine progress
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } eng_state_e;

endpackage

// File: rtl/mac_init_rst_sync.sv
module mac_init_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic meta_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      srst_n <= meta_q;
    end
  end

endmodule

// File: rtl/mac_init_rom.sv
module mac_init_rom
  import mac_init_pkg::*;
#(
  parameter int               ADDR_W     = 8,
  parameter int               DATA_W     = 32,
  parameter int               STEP_W     = 3,
  parameter bit               WITH_RGMII = 1'b0,
  parameter logic [ADDR_W-1:0] CMD_OFS   = '0,
  parameter logic [ADDR_W-1:0] FRM_OFS   = '0,
  parameter logic [ADDR_W-1:0] IFG_OFS   = '0,
  parameter logic [ADDR_W-1:0] MDIO_OFS  = '0,
  parameter logic [DATA_W-1:0] VAL_OFF   = '0,
  parameter logic [DATA_W-1:0] VAL_SRST  = '0,
  parameter logic [DATA_W-1:0] VAL_FRM   = '0,
  parameter logic [DATA_W-1:0] VAL_IFG   = '0,
  parameter logic [DATA_W-1:0] VAL_ON    = '0,
  parameter logic [DATA_W-1:0] VAL_MDIO  = '0
) (
  input  logic [STEP_W-1:0] step,
  output step_kind_e        kind,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);

  // interface-dependent tail entry
  logic [ADDR_W-1:0] tail_addr;
  logic [DATA_W-1:0] tail_data;

  if (WITH_RGMII) begin : g_rgmii
    assign tail_addr = MDIO_OFS;
    assign tail_data = VAL_MDIO;
  end else begin : g_sgmii
    assign tail_addr = CMD_OFS;
    assign tail_data = VAL_ON;
  end

  always_comb begin
    kind = K_WR;
    addr = CMD_OFS;
    data = '0;
    case (int'(step))
      0: data = VAL_OFF;
      1: data = VAL_SRST;
      2: kind = K_POLL;
      3: begin addr = FRM_OFS; data = VAL_FRM; end
      4: begin addr = IFG_OFS; data = VAL_IFG; end
      5: data = VAL_ON;
      6: begin addr = tail_addr; data = tail_data; end
      default: ;
    endcase
  end

endmodule

// File: rtl/mac_init_eng.sv
module mac_init_eng
  import mac_init_pkg::*;
#(
  parameter int               DATA_W    = 32,
  parameter int               STEP_W    = 3,
  parameter int               N_STEPS   = 6,
  parameter logic [DATA_W-1:0] BUSY_MASK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  step_kind_e        kind,
  input  logic              waitrequest,
  input  logic [DATA_W-1:0] readdata,
  output logic [STEP_W-1:0] step,
  output logic              active,
  output logic              done
);

  localparam logic [STEP_W-1:0] LAST = STEP_W'(N_STEPS - 1);

  eng_state_e        state_q, state_nx;
  logic [STEP_W-1:0] step_nx;
  logic              en;
  logic              still_busy;

  // a poll keeps its step while any reset bit still reads back set
  assign still_busy = (kind == K_POLL) && ((readdata & BUSY_MASK) != '0);
  assign en = (state_q == ST_IDLE) || ((state_q == ST_RUN) && !waitrequest);

  always_comb begin
    state_nx = state_q;
    step_nx  = step;
    case (state_q)
      ST_IDLE: state_nx = ST_RUN;
      ST_RUN: begin
        if (!still_busy) begin
          if (step == LAST) state_nx = ST_DONE;
          else              step_nx  = step + 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step    <= '0;
    end else if (en) begin
      state_q <= state_nx;
      step    <= step_nx;
    end
  end

  assign active = (state_q == ST_RUN);
  assign done   = (state_q == ST_DONE);

endmodule

// File: rtl/mac_init_seq.sv
module mac_init_seq
  import mac_init_pkg::*;
#(
  parameter int               ADDR_W     = 8,
  parameter int               DATA_W     = 32,
  parameter logic [ADDR_W-1:0] CMD_OFS   = 8'h08,
  parameter logic [ADDR_W-1:0] FRM_OFS   = 8'h14,
  parameter logic [ADDR_W-1:0] IFG_OFS   = 8'h5C,
  parameter logic [ADDR_W-1:0] MDIO_OFS  = 8'hA0,
  parameter logic [DATA_W-1:0] VAL_OFF   = 32'h0000_0000,
  parameter logic [DATA_W-1:0] VAL_SRST  = 32'h0000_2000,
  parameter logic [DATA_W-1:0] VAL_FRM   = 32'h0000_2580,
  parameter logic [DATA_W-1:0] VAL_IFG   = 32'h0000_000C,
  parameter logic [DATA_W-1:0] VAL_ON    = 32'h0000_0003,
  parameter logic [DATA_W-1:0] VAL_MDIO  = 32'h0000_0082,
  parameter bit               WITH_RGMII = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] avm_address,
  output logic              avm_read,
  output logic              avm_write,
  output logic [DATA_W-1:0] avm_writedata,
  input  logic [DATA_W-1:0] avm_readdata,
  input  logic              avm_waitrequest,
  output logic              init_done
);

  localparam int N_STEPS = WITH_RGMII ? 7 : 6;
  localparam int STEP_W  = $clog2(N_STEPS);

  logic              srst_n;
  logic [STEP_W-1:0] step;
  logic              active;
  step_kind_e        kind;
  logic [ADDR_W-1:0] rom_addr;
  logic [DATA_W-1:0] rom_data;

  mac_init_rst_sync i_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  mac_init_rom #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STEP_W(STEP_W), .WITH_RGMII(WITH_RGMII),
    .CMD_OFS(CMD_OFS), .FRM_OFS(FRM_OFS), .IFG_OFS(IFG_OFS), .MDIO_OFS(MDIO_OFS),
    .VAL_OFF(VAL_OFF), .VAL_SRST(VAL_SRST), .VAL_FRM(VAL_FRM),
    .VAL_IFG(VAL_IFG), .VAL_ON(VAL_ON), .VAL_MDIO(VAL_MDIO)
  ) i_rom (
    .step (step),
    .kind (kind),
    .addr (rom_addr),
    .data (rom_data)
  );

  mac_init_eng #(
    .DATA_W(DATA_W), .STEP_W(STEP_W), .N_STEPS(N_STEPS), .BUSY_MASK(VAL_SRST)
  ) i_eng (
    .clk         (clk),
    .rst_n       (srst_n),
    .kind        (kind),
    .waitrequest (avm_waitrequest),
    .readdata    (avm_readdata),
    .step        (step),
    .active      (active),
    .done        (init_done)
  );

  assign avm_read      = active && (kind == K_POLL);
  assign avm_write     = active && (kind == K_WR);
  assign avm_address   = active ? rom_addr : '0;
  assign avm_writedata = avm_write ? rom_data : '0;

endmodule

// File: rtl/mac_init_chk.sv
module mac_init_chk #(
  parameter int               ADDR_W  = 8,
  parameter int               DATA_W  = 32,
  parameter logic [ADDR_W-1:0] CMD_OFS = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] avm_address,
  input logic              avm_read,
  input logic              avm_write,
  input logic [DATA_W-1:0] avm_writedata,
  input logic              avm_waitrequest,
  input logic              init_done
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!avm_read && !avm_write && !init_done));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((avm_read || avm_write) && avm_waitrequest) |=>
      ($stable(avm_address) && $stable(avm_writedata) &&
       $stable(avm_read) && $stable(avm_write)));

  // R6
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(avm_read && avm_write));

  // R3
  poll_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    avm_read |-> (avm_address == CMD_OFS));

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (!avm_read && !avm_write));

endmodule

bind mac_init_seq mac_init_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_OFS(CMD_OFS)
) i_mac_init_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .avm_address     (avm_address),
  .avm_read        (avm_read),
  .avm_write       (avm_write),
  .avm_writedata   (avm_writedata),
  .avm_waitrequest (avm_waitrequest),
  .init_done       (init_done)
);

// File: tb/test_mac_init_seq.sv
module test_mac_init_seq;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int ENT_W  = 1 + ADDR_W + DATA_W;
  localparam logic [ADDR_W-1:0] P_CMD  = 8'h08;
  localparam logic [ADDR_W-1:0] P_FRM  = 8'h14;
  localparam logic [ADDR_W-1:0] P_IFG  = 8'h5C;
  localparam logic [ADDR_W-1:0] P_MDIO = 8'hA0;
  localparam logic [DATA_W-1:0] V_OFF  = 32'h0000_0000;
  localparam logic [DATA_W-1:0] V_SRST = 32'h0000_2000;
  localparam logic [DATA_W-1:0] V_FRM  = 32'h0000_2580;
  localparam logic [DATA_W-1:0] V_IFG  = 32'h0000_000C;
  localparam logic [DATA_W-1:0] V_ON   = 32'h0000_0003;
  localparam logic [DATA_W-1:0] V_MDIO = 32'h0000_0082;

  // expected writes in order {read, address, data}; reads are inserted after entry 1
  localparam logic [ENT_W-1:0] WR_TAB [6] = '{
    {1'b0, P_CMD,  V_OFF},
    {1'b0, P_CMD,  V_SRST},
    {1'b0, P_FRM,  V_FRM},
    {1'b0, P_IFG,  V_IFG},
    {1'b0, P_CMD,  V_ON},
    {1'b0, P_MDIO, V_MDIO}
  };
  localparam logic [ENT_W-1:0] RD_ENT = {1'b1, P_CMD, 32'h0};

  logic clk = 1'b0;
  always #5 clk = ~clk;
  logic rst_n;

  logic [ADDR_W-1:0] r_addr, s_addr;
  logic              r_rd, r_wr, s_rd, s_wr, r_wait, s_wait, r_done, s_done;
  logic [DATA_W-1:0] r_wd, s_wd, r_rdat, s_rdat;
  logic [3:0]        r_wcfg, s_wcfg, r_busy, s_busy;

  mac_init_seq #(.WITH_RGMII(1'b1)) i_mac_init_seq (
    .clk(clk), .rst_n(rst_n), .avm_address(r_addr), .avm_read(r_rd), .avm_write(r_wr),
    .avm_writedata(r_wd), .avm_readdata(r_rdat), .avm_waitrequest(r_wait), .init_done(r_done));

  mac_init_seq #(.WITH_RGMII(1'b0)) i_mac_init_seq_sgmii (
    .clk(clk), .rst_n(rst_n), .avm_address(s_addr), .avm_read(s_rd), .avm_write(s_wr),
    .avm_writedata(s_wd), .avm_readdata(s_rdat), .avm_waitrequest(s_wait), .init_done(s_done));

  test_mac_init_seq_slave #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_OFS(P_CMD), .SRST_MASK(V_SRST))
  i_slv_r (.clk(clk), .rst_n(rst_n), .address(r_addr), .read(r_rd), .write(r_wr),
           .writedata(r_wd), .wait_cfg(r_wcfg), .busy_cfg(r_busy),
           .waitrequest(r_wait), .readdata(r_rdat));

  test_mac_init_seq_slave #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_OFS(P_CMD), .SRST_MASK(V_SRST))
  i_slv_s (.clk(clk), .rst_n(rst_n), .address(s_addr), .read(s_rd), .write(s_wr),
           .writedata(s_wd), .wait_cfg(s_wcfg), .busy_cfg(s_busy),
           .waitrequest(s_wait), .readdata(s_rdat));

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  task automatic chk_eq(input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // compare a slave log with the table walked once, polls spliced in
  task automatic check_log(input string name, input bit rg, input int busy,
                           input logic [ENT_W-1:0] lg [16], input int n_log);
    int n_wr  = rg ? 6 : 5;
    int total = n_wr + busy + 1;
    int w     = 0;
    chk_eq("R5", {name, " access count"}, 64'(n_log), 64'(total));
    for (int i = 0; i < total; i++) begin
      logic [ENT_W-1:0] exp;
      string tag;
      if (i >= 2 && i < 3 + busy) begin
        exp = RD_ENT;
        tag = "R3";
      end else begin
        exp = WR_TAB[w];
        if (w < 2)                 tag = "R2";
        else if (rg && w == 5)     tag = "R5";
        else if (w == 2)           tag = "R3";
        else                       tag = "R4";
        w++;
      end
      chk_eq(tag, $sformatf("%s access %0d", name, i), 64'(lg[i]), 64'(exp));
    end
  endtask

  task automatic wait_both();
    bit   r_seen = 1'b0, s_seen = 1'b0;
    logic r_pacc = 1'b0, s_pacc = 1'b0;
    for (int c = 0; c < 600 && !(r_seen && s_seen); c++) begin
      @(negedge clk);
      if (r_done && !r_seen) begin
        r_seen = 1'b1;
        chk_eq("R7", "rgmii done right after last accept", 64'(r_pacc), 64'd1);
      end
      if (s_done && !s_seen) begin
        s_seen = 1'b1;
        chk_eq("R7", "sgmii done right after last accept", 64'(s_pacc), 64'd1);
      end
      r_pacc = (r_rd || r_wr) && !r_wait;
      s_pacc = (s_rd || s_wr) && !s_wait;
    end
    chk_eq("R7", "rgmii done reached", 64'(r_seen), 64'd1);
    chk_eq("R7", "sgmii done reached", 64'(s_seen), 64'd1);
  endtask

  task automatic check_reset(input string tag);
    chk_eq(tag, "rgmii bus idle in reset", {62'd0, r_rd, r_wr}, 64'd0);
    chk_eq(tag, "sgmii bus idle in reset", {62'd0, s_rd, s_wr}, 64'd0);
    chk_eq(tag, "rgmii done low in reset", 64'(r_done), 64'd0);
    chk_eq(tag, "sgmii done low in reset", 64'(s_done), 64'd0);
    chk_eq(tag, "address zero in reset", 64'({r_addr, s_addr}), 64'd0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int r_n0, s_n0;
    rst_n  = 1'b1;
    r_wcfg = 4'd2; r_busy = 4'd2;
    s_wcfg = 4'd0; s_busy = 4'd0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_reset("R1");

    // first run
    rst_n = 1'b1;
    wait_both();
    check_log("rgmii", 1'b1, 2, i_slv_r.log_q, i_slv_r.n_log);
    check_log("sgmii", 1'b0, 0, i_slv_s.log_q, i_slv_s.n_log);
    chk_eq("R6", "rgmii request changed while stalled", 64'(i_slv_r.n_unstable), 64'd0);
    chk_eq("R6", "sgmii request changed while stalled", 64'(i_slv_s.n_unstable), 64'd0);
    chk_eq("R6", "rgmii read with write", 64'(i_slv_r.n_both), 64'd0);

    // done holds, bus silent
    r_n0 = i_slv_r.n_log;
    s_n0 = i_slv_s.n_log;
    repeat (20) @(negedge clk);
    chk_eq("R7", "done still high", {62'd0, r_done, s_done}, 64'd3);
    chk_eq("R7", "no access after done", {62'd0, r_rd || r_wr, s_rd || s_wr}, 64'd0);
    chk_eq("R7", "logs unchanged after done", 64'({i_slv_r.n_log - r_n0, i_slv_s.n_log - s_n0}), 64'd0);

    // second reset, different stall and busy patterns
    rst_n = 1'b0;
    r_wcfg = 4'd1; r_busy = 4'd0;
    s_wcfg = 4'd3; s_busy = 4'd1;
    repeat (2) @(negedge clk);
    check_reset("R8");
    rst_n = 1'b1;
    wait_both();
    check_log("rgmii rerun R8", 1'b1, 0, i_slv_r.log_q, i_slv_r.n_log);
    check_log("sgmii rerun R8", 1'b0, 1, i_slv_s.log_q, i_slv_s.n_log);
    chk_eq("R6", "sgmii stall hold on rerun", 64'(i_slv_s.n_unstable), 64'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule

module test_mac_init_seq_slave #(
  parameter int               ADDR_W    = 8,
  parameter int               DATA_W    = 32,
  parameter logic [ADDR_W-1:0] CMD_OFS   = '0,
  parameter logic [DATA_W-1:0] SRST_MASK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] address,
  input  logic              read,
  input  logic              write,
  input  logic [DATA_W-1:0] writedata,
  input  logic [3:0]        wait_cfg,
  input  logic [3:0]        busy_cfg,
  output logic              waitrequest,
  output logic [DATA_W-1:0] readdata
);

  localparam int ENT_W = 1 + ADDR_W + DATA_W;

  logic [3:0]        wcnt;
  logic              srst_seen;
  int                n_polls;
  logic [ENT_W-1:0]  log_q [16];
  int                n_log;
  int                n_unstable;
  int                n_both;
  logic              pend_q, r_q, w_q;
  logic [ADDR_W-1:0] a_q;
  logic [DATA_W-1:0] d_q;

  assign waitrequest = (read || write) && (wcnt != wait_cfg);
  assign readdata    = (srst_seen && n_polls < int'(busy_cfg)) ? SRST_MASK : '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt       <= '0;
      srst_seen  <= 1'b0;
      n_polls    <= 0;
      n_log      <= 0;
      n_unstable <= 0;
      n_both     <= 0;
      pend_q     <= 1'b0;
      r_q        <= 1'b0;
      w_q        <= 1'b0;
      a_q        <= '0;
      d_q        <= '0;
      for (int i = 0; i < 16; i++) log_q[i] <= '0;
    end else begin
      if (pend_q && (address != a_q || read != r_q || write != w_q || writedata != d_q))
        n_unstable <= n_unstable + 1;
      if (read && write) n_both <= n_both + 1;
      pend_q <= (read || write) && waitrequest;
      r_q    <= read;
      w_q    <= write;
      a_q    <= address;
      d_q    <= writedata;
      if (read || write) begin
        if (waitrequest) begin
          wcnt <= wcnt + 1'b1;
        end else begin
          wcnt <= '0;
          if (n_log < 16) log_q[n_log] <= {read, address, read ? '0 : writedata};
          n_log <= n_log + 1;
          if (write && address == CMD_OFS && (writedata & SRST_MASK) != '0) srst_seen <= 1'b1;
          if (read && srst_seen) n_polls <= n_polls + 1;
        end
      end
    end
  end

endmodule